// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three independent 16-bit down-counters reached through a byte-wide port with a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is a write-only control port. Each channel has a count-enable input (one count per clock in which it is high), a gate input and an output pin. Software first writes a control byte. This byte picks the channel, the order in which its bytes are moved, the counting mode and binary or BCD format. Software then writes the reload value through the channel's data port.

Two counting modes are supported. The first raises the output once the count runs out. The second produces a square wave that the gate can hold and restart. A channel's count can be frozen into a holding register for a clean multi-byte read. A readback command can freeze the count, the status, or both, on any subset of the channels at once.

Each channel is a state machine with these states:
- `S_UNPROG`: not yet programmed; data writes are ignored.
- `S_WAIT_CNT`: a control byte has been taken and the channel waits for its count.
- `S_WAIT_HI`: the low byte of a two-byte count has been taken.
- `S_RUN`: the channel is counting.

The transitions are:
- PROGRAM: any state goes to `S_WAIT_CNT` on a control byte for the channel.
- FIRST_BYTE: `S_WAIT_CNT` or `S_RUN` goes to `S_WAIT_HI` on a low byte in two-byte order.
- LOAD: `S_WAIT_CNT` or `S_WAIT_HI` or `S_RUN` goes to `S_RUN` on the final byte.

Top module: `pit3_top`

## Requirements
- R1: A write to address 3 is a control byte. Bits 7-6 pick the channel, with 3 meaning readback. Bits 5-4 give the access order, bits 3-1 the mode and bit 0 selects BCD. A control byte with a non-zero access order programs the channel. It stops counting, sets the null-count flag and drives the output low in mode 0 and high in mode 3. The bytes 36h, 76h and B6h set channels 0, 1 and 2 to square wave, binary, low-then-high order.
- R2: Access order 1 loads the low byte with a zero high byte. Order 2 loads the high byte with a zero low byte. Order 3 takes the low byte and then the high byte. The count is loaded on the final byte. No counting happens while the channel waits for that byte.
- R3: A data port read returns a byte of the live count in the channel's access order. In order 3, successive reads alternate low, high. A read of address 3 returns 00h.
- R4: In mode 0 (mode codes other than 3 and 7), the count falls by one per enabled clock only while the gate is high. The output stays low until the count reaches 0. It then stays high until a new count is loaded.
- R5: In mode 3 (mode code 3 or 7) with reload N, the output is high for ceil(N/2) enabled clocks and low for floor(N/2), and then the count reloads. A reload of 0 means 65536, or 10000 in BCD.
- R6: In mode 3, a low gate holds the count and forces the output high. A rising gate reloads the count and restarts the high half.
- R7: In BCD format, each of the four digits wraps from 0 to 9 with a borrow, so 0100 becomes 0099 and 0000 becomes 9999.
- R8: A control byte with access order 0 freezes the count into a holding register. Reads return the frozen bytes until all of them have been read in access order. Counting goes on underneath. A second latch before the release has no effect.
- R9: A readback byte (bits 7-6 = 3) uses bits 1, 2 and 3 as the mask for channels 0, 1 and 2. Bit 5 low latches the count and bit 4 low latches the status. A latched status is read before the count. The status layout is bit 7 = output, bit 6 = null count, bits 5-0 = the channel's control bits.
- R10: A channel counts only in clocks where its count enable is high. With the enable low, the count holds.
- R11: After reset all counts are 0, all outputs are low and no channel is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one byte per clock |
| rd_en | input | 1 | Read strobe; advances the read order |
| addr | input | 2 | 0-2 data ports, 3 control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port (combinational) |
| cnt_en | input | 3 | Per-channel count enable |
| gate | input | 3 | Per-channel gate |
| tmr_out | output | 3 | Per-channel output pin |

## Verification
Writes, loads and counts take effect on the clock edge that samples the strobe or enable. The output pin and the live count are therefore due one edge later. The bench drives on the falling edge and samples on the next falling edge. `rdata` is combinational from the addressed channel's state, so a read returns what the previous edge left behind. The bench samples it just after driving `addr`, before the edge that moves the byte order. For the mode-3 waveform, the expected output after each enabled clock k is computed as (k mod N) < ceil(N/2). The expected live count is computed as N - (k mod N).

// File: rtl/pit3_pkg.sv
package pit3_pkg;

    parameter int NUM_CH  = 3;
    parameter int BYTE_W  = 8;
    parameter int CNT_W   = 2 * BYTE_W;
    parameter int CTL_W   = 6;
    localparam int PER_W  = CNT_W + 1;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        S_UNPROG,
        S_WAIT_CNT,
        S_WAIT_HI,
        S_RUN
    } ch_state_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctl_t;

    function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (borrow) begin
                if (v[d*4 +: 4] == 4'd0) begin
                    r[d*4 +: 4] = 4'd9;
                end else begin
                    r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [PER_W-1:0] bcd_to_bin(input logic [CNT_W-1:0] v);
        logic [PER_W-1:0] acc;
        acc = '0;
        for (int d = DIGITS - 1; d >= 0; d--) begin
            acc = PER_W'(acc * PER_W'(10)) + PER_W'(v[d*4 +: 4]);
        end
        return acc;
    endfunction

    function automatic logic [PER_W-1:0] bcd_full();
        logic [PER_W-1:0] p;
        p = PER_W'(1);
        for (int d = 0; d < DIGITS; d++) begin
            p = PER_W'(p * PER_W'(10));
        end
        return p;
    endfunction

endpackage

// File: rtl/pit3_decode.sv
module pit3_decode
    import pit3_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] prog_stb,
    output logic [NUM_CH-1:0] latch_stb,
    output logic [NUM_CH-1:0] slatch_stb,
    output logic [NUM_CH-1:0] dwr_stb,
    output logic [NUM_CH-1:0] rd_stb
);
    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0] SEL_RB   = 2'd3;

    logic       ctl_wr;
    logic [1:0] sel;
    acc_e       acc;

    assign ctl_wr = wr_en && (addr == CTL_ADDR);
    assign sel    = wdata[7:6];
    assign acc    = acc_e'(wdata[5:4]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        logic hit;
        logic rb_hit;
        assign hit           = ctl_wr && (sel == 2'(i));
        assign rb_hit        = ctl_wr && (sel == SEL_RB) && wdata[1+i];
        assign prog_stb[i]   = hit && (acc != ACC_LATCH);
        assign latch_stb[i]  = (hit && (acc == ACC_LATCH)) || (rb_hit && !wdata[5]);
        assign slatch_stb[i] = rb_hit && !wdata[4];
        assign dwr_stb[i]    = wr_en && (addr == 2'(i));
        assign rd_stb[i]     = rd_en && (addr == 2'(i));
    end

endmodule

// File: rtl/pit3_channel.sv
module pit3_channel
    import pit3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              gate,
    input  logic              prog_stb,
    input  logic [CTL_W-1:0]  ctl_in,
    input  logic              latch_stb,
    input  logic              slatch_stb,
    input  logic              dwr_stb,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rbyte,
    output logic              out
);
    ch_state_e        st_q, st_d;
    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q, reload_q, hold_q, ld_val, dec_v, src;
    logic [BYTE_W-1:0] lo_q, sts_q;
    logic [PER_W-1:0] el_q, per, hi_len, el_nx;
    logic             out_q, null_q, gate_q, lat_q, slat_q, rdhi_q;
    logic             sq, run, load, gate_rise, wait_any;

    assign sq        = (ctl_q.mode[1:0] == 2'b11);
    assign run       = (st_q == S_RUN);
    assign wait_any  = (st_q == S_WAIT_CNT) || (st_q == S_RUN);
    assign gate_rise = gate && !gate_q;
    assign load      = dwr_stb && !prog_stb &&
                       ((st_q == S_WAIT_HI) || (wait_any && (ctl_q.acc != ACC_LOHI)));

    always_comb begin
        if (st_q == S_WAIT_HI)         ld_val = {wbyte, lo_q};
        else if (ctl_q.acc == ACC_HI)  ld_val = {wbyte, BYTE_W'(0)};
        else                           ld_val = {BYTE_W'(0), wbyte};
    end

    always_comb begin
        if (reload_q == '0)  per = ctl_q.bcd ? bcd_full() : PER_W'(1) << CNT_W;
        else if (ctl_q.bcd)  per = bcd_to_bin(reload_q);
        else                 per = PER_W'(reload_q);
        hi_len = PER_W'((per + PER_W'(1)) >> 1);
        el_nx  = PER_W'(el_q + PER_W'(1));
        dec_v  = ctl_q.bcd ? bcd_dec(cnt_q) : cnt_q - CNT_W'(1);
    end

    // next-state logic: PROGRAM, FIRST_BYTE, LOAD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_UNPROG: begin
                if (prog_stb) st_d = S_WAIT_CNT;
            end
            S_WAIT_CNT, S_RUN: begin
                if (prog_stb)     st_d = S_WAIT_CNT;
                else if (dwr_stb) st_d = (ctl_q.acc == ACC_LOHI) ? S_WAIT_HI : S_RUN;
            end
            S_WAIT_HI: begin
                if (prog_stb)     st_d = S_WAIT_CNT;
                else if (dwr_stb) st_d = S_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_UNPROG;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            cnt_q    <= '0;
            reload_q <= '0;
            hold_q   <= '0;
            lo_q     <= '0;
            sts_q    <= '0;
            el_q     <= '0;
            out_q    <= 1'b0;
            null_q   <= 1'b0;
            gate_q   <= 1'b0;
            lat_q    <= 1'b0;
            slat_q   <= 1'b0;
            rdhi_q   <= 1'b0;
        end else begin
            gate_q <= gate;
            if (prog_stb) begin
                ctl_q  <= ctl_t'(ctl_in);
                out_q  <= (ctl_in[2:1] == 2'b11);
                null_q <= 1'b1;
                lat_q  <= 1'b0;
                slat_q <= 1'b0;
                rdhi_q <= 1'b0;
            end else begin
                if (dwr_stb && wait_any && !load) lo_q <= wbyte;
                if (load) begin
                    reload_q <= ld_val;
                    cnt_q    <= ld_val;
                    el_q     <= '0;
                    null_q   <= 1'b0;
                    out_q    <= sq;
                end else if (run && sq) begin
                    if (!gate) begin
                        out_q <= 1'b1;
                    end else if (gate_rise) begin
                        cnt_q <= reload_q;
                        el_q  <= '0;
                        out_q <= 1'b1;
                    end else if (ce) begin
                        if (el_nx == per) begin
                            cnt_q <= reload_q;
                            el_q  <= '0;
                            out_q <= 1'b1;
                        end else begin
                            cnt_q <= dec_v;
                            el_q  <= el_nx;
                            out_q <= (el_nx < hi_len);
                        end
                    end
                end else if (run && ce && gate) begin
                    cnt_q <= dec_v;
                    if (dec_v == '0) out_q <= 1'b1;
                end
                if (rd_stb) begin
                    if (slat_q) begin
                        slat_q <= 1'b0;
                    end else if (ctl_q.acc == ACC_LOHI) begin
                        rdhi_q <= !rdhi_q;
                        if (rdhi_q) lat_q <= 1'b0;
                    end else begin
                        lat_q <= 1'b0;
                    end
                end
                if (latch_stb && !lat_q) begin
                    hold_q <= cnt_q;
                    lat_q  <= 1'b1;
                end
                if (slatch_stb && !slat_q) begin
                    sts_q  <= {out_q, null_q, ctl_q};
                    slat_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        src = lat_q ? hold_q : cnt_q;
        if (slat_q)                      rbyte = sts_q;
        else if (ctl_q.acc == ACC_HI)    rbyte = src[CNT_W-1:BYTE_W];
        else if (ctl_q.acc == ACC_LOHI)  rbyte = rdhi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        else                             rbyte = src[BYTE_W-1:0];
    end

    assign out = out_q;

    // R1
    prog_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |=> (st_q == S_WAIT_CNT) && null_q);

    // R4
    term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sq && out_q && !prog_stb && !load) |=> out_q);

    // R6
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sq && !gate && !prog_stb) |=> out_q && $stable(cnt_q));

    // R8
    latch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !rd_stb && !prog_stb) |=> lat_q && $stable(hold_q));

    // R5
    sq_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sq) |-> (el_q < per));

endmodule

// File: rtl/pit3_top.sv
module pit3_top
    import pit3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [2:0]        cnt_en,
    input  logic [2:0]        gate,
    output logic [2:0]        tmr_out
);
    logic [NUM_CH-1:0] prog_stb, latch_stb, slatch_stb, dwr_stb, rd_stb;
    logic [BYTE_W-1:0] rbyte [NUM_CH];

    pit3_decode u_dec (
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .prog_stb   (prog_stb),
        .latch_stb  (latch_stb),
        .slatch_stb (slatch_stb),
        .dwr_stb    (dwr_stb),
        .rd_stb     (rd_stb)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pit3_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ce         (cnt_en[i]),
            .gate       (gate[i]),
            .prog_stb   (prog_stb[i]),
            .ctl_in     (wdata[CTL_W-1:0]),
            .latch_stb  (latch_stb[i]),
            .slatch_stb (slatch_stb[i]),
            .dwr_stb    (dwr_stb[i]),
            .wbyte      (wdata),
            .rd_stb     (rd_stb[i]),
            .rbyte      (rbyte[i]),
            .out        (tmr_out[i])
        );
    end

    always_comb begin
        unique case (addr)
            2'd0:    rdata = rbyte[0];
            2'd1:    rdata = rbyte[1];
            2'd2:    rdata = rbyte[2];
            default: rdata = '0;
        endcase
    end

    // R1
    one_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_stb));

    // R9
    rb_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[7:6] == 2'd3) |-> (prog_stb == '0));

endmodule

// File: tb/pit3_top_tb_top.sv
module pit3_top_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] cnt_en = '0, gate = 3'b111;
    logic [2:0] tmr_out;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    pit3_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .gate(gate), .tmr_out(tmr_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] bin2bcd(input int v);
        logic [15:0] r;
        int t;
        t = v;
        for (int d = 0; d < 4; d++) begin
            r[d*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic bit sq_out(input int e, input int p);
        return e < (p + 1) / 2;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        addr = 2'(a); wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = 2'(a);
        #1 v = int'(rdata);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(input int ch, output int v);
        int lo, hi;
        rd(ch, lo);
        rd(ch, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic tick(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            cnt_en[ch] = 1'b1;
            @(negedge clk);
            cnt_en[ch] = 1'b0;
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected done");
            report();
        end
    end

    initial begin
        int v, s;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 outputs", int'(tmr_out), 0);
        rd(0, v); chk("R11 count", v, 0);

        // R1 square-wave setup bytes
        wr(3, 'h36); wr(3, 'h76); wr(3, 'hB6);
        chk("R1 mode3 outputs high", int'(tmr_out), 7);
        wr(3, 'hE4);
        rd(1, v); chk("R9 status ch1 null", v, 'hF6);

        // R5 even reload on ch0
        wr(0, 10); wr(0, 0);
        for (int k = 1; k <= 20; k++) begin
            tick(0, 1);
            chk("R5 even wave", int'(tmr_out[0]), int'(sq_out(k % 10, 10)));
        end
        tick(0, 3);
        rd16(0, v); chk("R3 live count", v, 7);

        // R5 odd reload on ch1
        wr(1, 7); wr(1, 0);
        for (int k = 1; k <= 14; k++) begin
            tick(1, 1);
            chk("R5 odd wave", int'(tmr_out[1]), int'(sq_out(k % 7, 7)));
        end

        // R6 gate hold and restart on ch2
        wr(2, 8); wr(2, 0);
        tick(2, 5);
        chk("R6 low half", int'(tmr_out[2]), 0);
        gate[2] = 1'b0; @(negedge clk);
        chk("R6 gate low forces high", int'(tmr_out[2]), 1);
        tick(2, 3);
        rd16(2, v); chk("R6 count held", v, 3);
        gate[2] = 1'b1; @(negedge clk);
        rd16(2, v); chk("R6 restart reload", v, 8);
        tick(2, 4);
        chk("R6 restarted wave", int'(tmr_out[2]), 0);

        // R4 mode 0 on ch0
        wr(3, 'h30);
        chk("R4 low after control", int'(tmr_out[0]), 0);
        wr(0, 5); wr(0, 0);
        gate[0] = 1'b0; tick(0, 3); gate[0] = 1'b1;
        rd16(0, v); chk("R4 gate low holds", v, 5);
        tick(0, 4);
        chk("R4 low before zero", int'(tmr_out[0]), 0);
        tick(0, 1);
        chk("R4 high at zero", int'(tmr_out[0]), 1);
        tick(0, 2);
        chk("R4 stays high", int'(tmr_out[0]), 1);
        rd16(0, v); chk("R4 wraps", v, 'hFFFE);
        wr(0, 3);
        chk("R4 high until full load", int'(tmr_out[0]), 1);
        wr(0, 0);
        chk("R4 low after reload", int'(tmr_out[0]), 0);

        // R10 enable low holds count
        repeat (20) @(negedge clk);
        rd16(0, v); chk("R10 no enable", v, 3);

        // R7 BCD mode 0 on ch1
        wr(3, 'h71); wr(1, 'h00); wr(1, 'h01);
        tick(1, 1);
        rd16(1, v); chk("R7 0100 to 0099", v, 'h0099);
        tick(1, 99);
        chk("R7 zero raises out", int'(tmr_out[1]), 1);
        tick(1, 1);
        rd16(1, v); chk("R7 0000 to 9999", v, 'h9999);

        // R2 access orders on ch2
        wr(3, 'h90); wr(2, 'h05);
        rd(2, v); chk("R2 low only", v, 'h05);
        rd(2, v); chk("R2 low only again", v, 'h05);
        wr(3, 'hA0); wr(2, 'h02);
        rd(2, v); chk("R2 high only", v, 'h02);
        wr(3, 'hB0); wr(2, 'h10);
        tick(2, 3);
        wr(2, 'h00);
        rd16(2, v); chk("R2 no count while waiting", v, 'h0010);

        // R3 control port reads zero
        rd(3, v); chk("R3 addr3 read", v, 0);

        // R8 latch on ch1
        wr(3, 'h76); wr(1, 'hE8); wr(1, 'h03);
        tick(1, 10);
        wr(3, 'h40);
        tick(1, 5);
        rd(1, v); chk("R8 frozen low", v, 'hDE);
        tick(1, 2);
        wr(3, 'h40);
        rd(1, v); chk("R8 frozen high", v, 'h03);
        rd16(1, v); chk("R8 live after release", v, 983);

        // R9 readback count and status on ch0 and ch2
        wr(3, 'hCA);
        tick(0, 1); tick(2, 1);
        rd(0, v); chk("R9 status ch0", v, 'h30);
        rd16(0, v); chk("R9 count ch0", v, 3);
        rd(2, v); chk("R9 status ch2", v, 'h30);
        rd16(2, v); chk("R9 count ch2", v, 'h10);
        rd16(0, v); chk("R9 live after readback", v, 2);

        // R5 BCD reload 0 means 10000
        wr(3, 'h37); wr(0, 0); wr(0, 0);
        tick(0, 3);
        rd16(0, v); chk("R5 bcd zero reload", v, 'h9997);
        chk("R5 bcd high half", int'(tmr_out[0]), 1);
        tick(0, 4997);
        chk("R5 bcd low half", int'(tmr_out[0]), 0);

        // R5 R7 random square-wave runs
        for (int it = 0; it < 8; it++) begin
            int ch, n, k, e, bcd, ld, expc;
            ch  = int'($urandom % 3);
            bcd = int'($urandom % 2);
            n   = 2 + int'($urandom % 399);
            k   = int'($urandom % 900);
            ld  = bcd ? int'(bin2bcd(n)) : n;
            wr(3, (ch << 6) | 'h36 | bcd);
            wr(ch, ld & 'hFF); wr(ch, ld >> 8);
            tick(ch, k);
            e    = k % n;
            expc = bcd ? int'(bin2bcd(n - e)) : n - e;
            rd16(ch, s); chk("R5 random count", s, expc);
            chk("R5 random out", int'(tmr_out[ch]), int'(sq_out(e, n)));
        end

        done = 1;
        report();
    end
endmodule